// File: doc/BRIEF.md
# Paired Column Histogram with Aligned Product Readout

This block sits after a thresholding stage in a lane-marking pipeline. Each incoming pixel carries two one-bit flags: one marks a strong positive filter response, the other a strong negative one. A valid strobe and the pixel's column index come with them. Over a band of consecutive image lines, the block counts flagged pixels per column. It keeps the positive and negative counts apart. The block tracks lines by itself: a line ends when an accepted pixel arrives at the last column. A band ends after a fixed number of such lines.

Two storage banks take turns. While the block accumulates the current band in one bank, it streams the band just finished out of the other, one column per clock. On the way out, the positive count stream is delayed by a fixed number of columns, matching the filter kernel width. Each delayed positive count is multiplied by the negative count of the current column. A high product marks a column where a positive track lies just left of a negative track. The first columns of each readout have no delayed partner and output zero. The readout carries start-of-band and end-of-band markers.

Top module: `hist_ovl_top`

## Requirements
- R1: After reset, `out_valid`, `out_sob` and `out_eob` are low, and they stay low until a full band has been accepted.
- R2: For each band of `BAND_LINES` lines, the block counts accepted pixels with `in_pos` = 1 per column, and separately accepted pixels with `in_neg` = 1 per column. A line ends on an accepted pixel with `in_col` = `COLS`-1. Counts reach `BAND_LINES` without wrapping.
- R3: Counts restart at each band. Nothing from an earlier band contributes to a later band's products.
- R4: A cycle with `in_valid` = 0 changes no count and ends no line, whatever `in_pos`, `in_neg` and `in_col` carry.
- R5: Once a band completes, the block emits exactly `COLS` outputs with `out_valid` high on consecutive cycles, with `out_col` running 0 through `COLS`-1. It emits no output before the band completes.
- R6: `out_sob` is high exactly on the output with `out_col` = 0. `out_eob` is high exactly on the output with `out_col` = `COLS`-1.
- R7: For column c >= `SHIFT`, `out_prod` equals the positive count of column c-`SHIFT` times the negative count of column c, both from the same band.
- R8: For column c < `SHIFT`, `out_prod` is 0, even when the counts are nonzero.
- R9: A new band's pixels may start on the clock right after the previous band's last pixel, with no stall. The readout of one band overlaps the accumulation of the next, and both bands give correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel strobe |
| in_pos | input | 1 | Positive-threshold flag of the pixel |
| in_neg | input | 1 | Negative-threshold flag of the pixel |
| in_col | input | $clog2(COLS) | Column index of the pixel |
| out_valid | output | 1 | Readout product valid |
| out_sob | output | 1 | First column of a band readout |
| out_eob | output | 1 | Last column of a band readout |
| out_col | output | $clog2(COLS) | Column of the current product |
| out_prod | output | 2*$clog2(BAND_LINES+1) | Delayed positive count times negative count |

## Verification
The bench builds the block with `COLS` = 16, `BAND_LINES` = 3 and `SHIFT` = 4. Every column of every band can then be checked against products computed arithmetically in the bench. A band of all-set flags drives the 2-bit counts to their maximum of 3 and the product to 9. A sparse band follows it, to show that counts restart. Another band interleaves idle cycles with all flags set, to show those cycles are ignored. Bands follow each other with no gap, so each readout overlaps the next band's accumulation and both banks swap roles several times.

// File: rtl/hcol_pkg.sv
package hcol_pkg;
  // identifies one of the two alternating histogram banks
  typedef logic bank_sel_t;
  localparam int BANKS = 2;
endpackage

// File: rtl/hcol_bank.sv
module hcol_bank #(
  parameter int DEPTH = 640,
  parameter int AW    = 10,
  parameter int DW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hcol_ctrl.sv
module hcol_ctrl
  import hcol_pkg::*;
#(
  parameter int COLS       = 640,
  parameter int BAND_LINES = 18,
  parameter int COL_W      = 10,
  parameter int CNT_W      = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic                              in_pos,
  input  logic                              in_neg,
  input  logic [COL_W-1:0]                  in_col,
  output logic [BANKS-1:0]                  bank_we,
  output logic [COL_W-1:0]                  bank_waddr,
  output logic [2*CNT_W-1:0]                bank_wdata,
  output logic [BANKS-1:0][COL_W-1:0]       bank_raddr,
  input  logic [BANKS-1:0][2*CNT_W-1:0]     bank_rdata,
  output logic                              d_valid,
  output logic [COL_W-1:0]                  d_col,
  output logic [CNT_W-1:0]                  d_pos,
  output logic [CNT_W-1:0]                  d_neg
);
  localparam int LINE_W = (BAND_LINES > 1) ? $clog2(BAND_LINES) : 1;
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(BAND_LINES - 1);

  // accumulation side
  bank_sel_t          acc_bank;
  logic [LINE_W-1:0]  line_cnt;
  logic               s1_valid, s1_pos, s1_neg, s1_first;
  logic [COL_W-1:0]   s1_col;
  bank_sel_t          s1_bank;
  // readout side
  logic               ro_active;
  logic [COL_W-1:0]   ro_col;
  bank_sel_t          ro_bank;
  logic               rv1;
  logic [COL_W-1:0]   rc1;
  bank_sel_t          rbank1;

  logic last_px, band_end;
  assign last_px  = in_valid && (in_col == LAST_COL);
  assign band_end = last_px && (line_cnt == LAST_LINE);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_bank  <= 1'b0;
      line_cnt  <= '0;
      s1_valid  <= 1'b0;
      s1_pos    <= 1'b0;
      s1_neg    <= 1'b0;
      s1_first  <= 1'b0;
      s1_col    <= '0;
      s1_bank   <= 1'b0;
      ro_active <= 1'b0;
      ro_col    <= '0;
      ro_bank   <= 1'b0;
      rv1       <= 1'b0;
      rc1       <= '0;
      rbank1    <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_pos   <= in_pos;
      s1_neg   <= in_neg;
      s1_col   <= in_col;
      s1_first <= (line_cnt == '0);
      s1_bank  <= acc_bank;
      if (last_px) line_cnt <= band_end ? '0 : line_cnt + LINE_W'(1);
      if (band_end) begin
        acc_bank  <= ~acc_bank;
        ro_bank   <= acc_bank;
        ro_active <= 1'b1;
        ro_col    <= '0;
      end else if (ro_active) begin
        if (ro_col == LAST_COL) ro_active <= 1'b0;
        else                    ro_col    <= ro_col + COL_W'(1);
      end
      rv1    <= ro_active;
      rc1    <= ro_col;
      rbank1 <= ro_bank;
    end
  end

  // read-modify-write: the first line of a band overwrites instead of adding
  logic [2*CNT_W-1:0] acc_rd;
  logic [CNT_W-1:0]   old_pos, old_neg, new_pos, new_neg;
  always_comb begin
    acc_rd  = bank_rdata[s1_bank];
    old_pos = s1_first ? '0 : acc_rd[2*CNT_W-1:CNT_W];
    old_neg = s1_first ? '0 : acc_rd[CNT_W-1:0];
    new_pos = old_pos + CNT_W'(s1_pos);
    new_neg = old_neg + CNT_W'(s1_neg);
  end
  assign bank_waddr = s1_col;
  assign bank_wdata = {new_pos, new_neg};

  for (genvar b = 0; b < BANKS; b++) begin : g_port
    assign bank_we[b]    = s1_valid && (s1_bank == bank_sel_t'(b));
    assign bank_raddr[b] = (acc_bank == bank_sel_t'(b)) ? in_col : ro_col;
  end

  logic [2*CNT_W-1:0] ro_rd;
  assign ro_rd   = bank_rdata[rbank1];
  assign d_valid = rv1;
  assign d_col   = rc1;
  assign d_pos   = ro_rd[2*CNT_W-1:CNT_W];
  assign d_neg   = ro_rd[CNT_W-1:0];

  // R9: the bank being read out is never the one being accumulated
  a_r9_bank_split: assert property (@(posedge clk) disable iff (rst)
    ro_active |-> (ro_bank != acc_bank));
  // R2: a written count never exceeds the band height
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (bank_we != '0) |-> (new_pos <= CNT_W'(BAND_LINES) && new_neg <= CNT_W'(BAND_LINES)));
  // R4: no line advance without an accepted pixel
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(line_cnt));
endmodule

// File: rtl/hcol_ovl_mult.sv
module hcol_ovl_mult #(
  parameter int COLS  = 640,
  parameter int COL_W = 10,
  parameter int CNT_W = 5,
  parameter int SHIFT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 d_valid,
  input  logic [COL_W-1:0]     d_col,
  input  logic [CNT_W-1:0]     d_pos,
  input  logic [CNT_W-1:0]     d_neg,
  output logic                 out_valid,
  output logic                 out_sob,
  output logic                 out_eob,
  output logic [COL_W-1:0]     out_col,
  output logic [2*CNT_W-1:0]   out_prod
);
  localparam logic [COL_W-1:0] SHIFT_C  = COL_W'(SHIFT);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic [SHIFT-1:0][CNT_W-1:0] pdly;
  logic                        a_valid;
  logic [COL_W-1:0]            a_col;
  logic [CNT_W-1:0]            a_pos, a_neg;

  // delay line advances one column per valid readout word
  always_ff @(posedge clk) begin
    if (d_valid) begin
      pdly[0] <= d_pos;
      for (int i = 1; i < SHIFT; i++) pdly[i] <= pdly[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid   <= 1'b0;
      a_col     <= '0;
      a_pos     <= '0;
      a_neg     <= '0;
      out_valid <= 1'b0;
      out_sob   <= 1'b0;
      out_eob   <= 1'b0;
      out_col   <= '0;
      out_prod  <= '0;
    end else begin
      a_valid   <= d_valid;
      a_col     <= d_col;
      a_pos     <= (d_col >= SHIFT_C) ? pdly[SHIFT-1] : '0;
      a_neg     <= d_neg;
      out_valid <= a_valid;
      out_sob   <= a_valid && (a_col == '0);
      out_eob   <= a_valid && (a_col == LAST_COL);
      out_col   <= a_col;
      out_prod  <= a_pos * a_neg;
    end
  end

  // R5: columns advance by one on consecutive cycles within a readout
  a_r5_col_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_col != '0) |-> ($past(out_valid) && out_col == $past(out_col) + COL_W'(1)));
  // R8: leading columns carry no product
  a_r8_head_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_col < SHIFT_C) |-> (out_prod == '0));
  // R6: end marker only on the last column
  a_r6_eob_col: assert property (@(posedge clk) disable iff (rst)
    out_eob |-> (out_valid && out_col == LAST_COL));
  // R6: start marker only on column zero
  a_r6_sob_col: assert property (@(posedge clk) disable iff (rst)
    out_sob |-> (out_valid && out_col == '0));
endmodule

// File: rtl/hist_ovl_top.sv
module hist_ovl_top
  import hcol_pkg::*;
#(
  parameter int COLS       = 640,
  parameter int BAND_LINES = 18,
  parameter int SHIFT      = 8,
  localparam int COL_W     = $clog2(COLS),
  localparam int CNT_W     = $clog2(BAND_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_pos,
  input  logic               in_neg,
  input  logic [COL_W-1:0]   in_col,
  output logic               out_valid,
  output logic               out_sob,
  output logic               out_eob,
  output logic [COL_W-1:0]   out_col,
  output logic [2*CNT_W-1:0] out_prod
);
  logic [BANKS-1:0]              bank_we;
  logic [COL_W-1:0]              bank_waddr;
  logic [2*CNT_W-1:0]            bank_wdata;
  logic [BANKS-1:0][COL_W-1:0]   bank_raddr;
  logic [BANKS-1:0][2*CNT_W-1:0] bank_rdata;
  logic                          d_valid;
  logic [COL_W-1:0]              d_col;
  logic [CNT_W-1:0]              d_pos, d_neg;

  hcol_ctrl #(
    .COLS(COLS), .BAND_LINES(BAND_LINES), .COL_W(COL_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_pos(in_pos), .in_neg(in_neg), .in_col(in_col),
    .bank_we(bank_we), .bank_waddr(bank_waddr), .bank_wdata(bank_wdata),
    .bank_raddr(bank_raddr), .bank_rdata(bank_rdata),
    .d_valid(d_valid), .d_col(d_col), .d_pos(d_pos), .d_neg(d_neg)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    hcol_bank #(.DEPTH(COLS), .AW(COL_W), .DW(2*CNT_W)) u_bank (
      .clk(clk), .we(bank_we[b]), .waddr(bank_waddr), .wdata(bank_wdata),
      .raddr(bank_raddr[b]), .rdata(bank_rdata[b])
    );
  end

  hcol_ovl_mult #(
    .COLS(COLS), .COL_W(COL_W), .CNT_W(CNT_W), .SHIFT(SHIFT)
  ) u_ovl (
    .clk(clk), .rst(rst),
    .d_valid(d_valid), .d_col(d_col), .d_pos(d_pos), .d_neg(d_neg),
    .out_valid(out_valid), .out_sob(out_sob), .out_eob(out_eob),
    .out_col(out_col), .out_prod(out_prod)
  );
endmodule

// File: tb/test_hist_ovl_top.sv
module test_hist_ovl_top;
  localparam int COLS  = 16;
  localparam int BAND  = 3;
  localparam int SHIFT = 4;
  localparam int COL_W = $clog2(COLS);
  localparam int CNT_W = $clog2(BAND + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_pos = 1'b0, in_neg = 1'b0;
  logic [COL_W-1:0] in_col = '0;
  logic out_valid, out_sob, out_eob;
  logic [COL_W-1:0] out_col;
  logic [2*CNT_W-1:0] out_prod;

  always #10 clk = ~clk;

  hist_ovl_top #(.COLS(COLS), .BAND_LINES(BAND), .SHIFT(SHIFT)) i_hist_ovl_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pos(in_pos), .in_neg(in_neg),
    .in_col(in_col), .out_valid(out_valid), .out_sob(out_sob), .out_eob(out_eob),
    .out_col(out_col), .out_prod(out_prod)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int pc [COLS];
  int nc [COLS];
  int lines = 0;
  int exp_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic void pattern(input int mode, input int b, input int l, input int c,
                                  output bit p, output bit n);
    case (mode)
      0: begin p = 0; n = 0; end
      1: begin p = 1; n = 1; end
      2: begin p = ((c*5 + l*3 + b) % 4 == 0) || (c == 6); n = ((c*3 + l + b*2) % 3 == 0); end
      default: begin p = (l == 1) && (c % 3 == 0); n = (c % 2 == 1); end
    endcase
  endfunction

  task automatic drive(input bit v, input bit p, input bit n, input int c, input string tag);
    @(posedge clk);
    #1;
    in_valid = v; in_pos = p; in_neg = n; in_col = COL_W'(c);
    if (v) begin
      pc[c] += int'(p);
      nc[c] += int'(n);
      if (c == COLS - 1) begin
        lines++;
        if (lines == BAND) begin
          for (int k = 0; k < COLS; k++) begin
            exp_q.push_back((k >= SHIFT) ? pc[k-SHIFT] * nc[k] : 0);
            tag_q.push_back((k < SHIFT) ? "R8" : tag);
          end
          for (int k = 0; k < COLS; k++) begin pc[k] = 0; nc[k] = 0; end
          lines = 0;
        end
      end
    end
  endtask

  task automatic run_band(input int mode, input int b, input bit gaps, input string tag);
    for (int l = 0; l < BAND; l++) begin
      for (int c = 0; c < COLS; c++) begin
        bit p, n;
        pattern(mode, b, l, c, p, n);
        if (gaps) drive(1'b0, 1'b1, 1'b1, COLS - 1, tag);  // R4: ignored idle cycle
        drive(1'b1, p, n, c, tag);
      end
    end
  endtask

  // output monitor
  int ecol = 0;
  bit prev_valid = 1'b0;
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected output", int'(out_col), -1);
      end else begin
        int ev;
        string tg;
        ev = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(int'(out_col) == ecol, "R5 column order", int'(out_col), ecol);
        check(ecol == 0 || prev_valid, "R5 consecutive", int'(prev_valid), 1);
        check(out_sob == (ecol == 0), "R6 sob", int'(out_sob), int'(ecol == 0));
        check(out_eob == (ecol == COLS - 1), "R6 eob", int'(out_eob), int'(ecol == COLS - 1));
        check(int'(out_prod) == ev, tg, int'(out_prod), ev);
        ecol = (ecol + 1) % COLS;
      end
    end
    prev_valid = out_valid;
  end

  initial begin
    for (int k = 0; k < COLS; k++) begin pc[k] = 0; nc[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!out_valid && !out_sob && !out_eob, "R1 reset outputs",
            int'({out_valid, out_sob, out_eob}), 0);
    end
    run_band(0, 0, 1'b0, "R2");   // all clear
    run_band(1, 1, 1'b0, "R2");   // saturating band, products reach 9
    run_band(3, 2, 1'b0, "R3");   // sparse band right after full one
    run_band(2, 3, 1'b0, "R7");
    run_band(2, 4, 1'b1, "R4");   // idle cycles carrying set flags
    run_band(2, 5, 1'b0, "R9");   // back-to-back bank swap
    drive(1'b0, 1'b0, 1'b0, 0, "R5");
    repeat (4 * COLS) @(posedge clk);
    check(exp_q.size() == 0, "R5 all outputs delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule